// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines and drives one interrupt line to a processor. The line is raised whenever an unmasked request is eligible. A request is eligible when it outranks every level that is currently in service. When several requests are eligible at once, the one with the highest rank wins. Its level number is returned as a 3-bit vector when the processor acknowledges.

Ranks are not fixed. Software writes a "lowest level" value L. A level i then has rank (i - L) mod 8, where rank 7 is the highest and rank 0 the lowest. Level L is therefore the lowest, and level L-1 (mod 8) is the highest. After reset L is 0, so level 7 is the highest. An acknowledge marks the winner as in service. An end-of-interrupt write releases the highest-ranked level that is in service, so nested service unwinds in order.

The configuration port takes a write strobe, a 2-bit select and 8 data bits:
- select 0 loads the mask (bit i set masks level i);
- select 1 loads L from data bits 2:0;
- select 2 is the end-of-interrupt command;
- select 3 is ignored.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all eight mask bits are set, no level is in service, L is 0 and ack_vec is 0. With every request line high, irq_out stays 0.
- R2: A level whose mask bit is set never causes irq_out to assert.
- R3: irq_out is registered. One clock edge after the inputs or the state change, it equals 1 exactly when some level is requesting, unmasked and ranked above every in-service level. It is therefore low within one clock after the last eligible request is removed or masked.
- R4: The rank of level i is (i - L) mod 8, with rank 7 highest. Writing select 1 takes effect from the next edge.
- R5: On an acknowledge with an eligible request present, ack_vec is loaded with the level number of the highest-ranked eligible request, and that level's in-service bit is set.
- R6: An in-service level blocks new interrupts from itself and from every lower-ranked level. Higher-ranked levels still interrupt, which gives nesting.
- R7: An end-of-interrupt write (select 2) clears only the in-service bit of the highest-ranked level in service. It does nothing when no level is in service.
- R8: An acknowledge with no eligible request sets no in-service bit and loads ack_vec with L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 8 | Level-sensitive request lines, bit i = level i |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 mask, 1 lowest level, 2 end-of-interrupt, 3 none |
| cfg_wdata | input | 8 | Write data |
| ack | input | 1 | Acknowledge strobe from the processor |
| irq_out | output | 1 | Interrupt line to the processor |
| ack_vec | output | 3 | Level number latched by the last acknowledge |

## Verification
The bench builds the block with its only configuration: eight levels and a 3-bit rank. This is small enough to sweep all 256 request patterns under each of the eight rotation settings. Each pattern covers acknowledge, blocking by the newly in-service level, and release. An all-zero pattern in each sweep covers the spurious acknowledge. Directed sequences then cover nesting, ordered end-of-interrupt release, masking, and a mask write while a request is held.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NLVL = 8;
  localparam int LW   = $clog2(NLVL);
  typedef logic [LW-1:0] lvl_t;

  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_LOW  = 2'd1;
  localparam logic [1:0] SEL_EOI  = 2'd2;

  // rank of a level given the lowest level; wraps in LW bits
  function automatic lvl_t rank_of(lvl_t lvl, lvl_t low);
    return lvl_t'(lvl - low);
  endfunction

  // level holding a given rank
  function automatic lvl_t lvl_at(lvl_t rank, lvl_t low);
    return lvl_t'(low + rank);
  endfunction

  function automatic logic [NLVL-1:0] onehot(lvl_t lvl);
    logic [NLVL-1:0] v;
    v = '0;
    v[lvl] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pic_resolve.sv
module pic_resolve
  import pic_pkg::*;
(
  input  logic [NLVL-1:0] cand,
  input  lvl_t            low,
  output logic            any,
  output lvl_t            win_lvl,
  output lvl_t            win_rank
);
  always_comb begin
    lvl_t rr;
    lvl_t ll;
    any      = 1'b0;
    win_lvl  = low;
    win_rank = '0;
    for (int r = 0; r < NLVL; r++) begin
      rr = lvl_t'(r);
      ll = lvl_at(rr, low);
      if (cand[ll]) begin
        any      = 1'b1;
        win_lvl  = ll;
        win_rank = rr;
      end
    end
  end
endmodule

// File: rtl/pic_state.sv
module pic_state
  import pic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [7:0]      cfg_wdata,
  input  logic [NLVL-1:0] isr_set,
  input  logic [NLVL-1:0] isr_clr,
  output logic [NLVL-1:0] mask_q,
  output lvl_t            low_q,
  output logic [NLVL-1:0] isr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      low_q  <= '0;
      isr_q  <= '0;
    end else begin
      if (cfg_we && cfg_sel == SEL_MASK) mask_q <= cfg_wdata[NLVL-1:0];
      if (cfg_we && cfg_sel == SEL_LOW)  low_q  <= cfg_wdata[LW-1:0];
      isr_q <= (isr_q & ~isr_clr) | isr_set;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_req,
  input  logic       cfg_we,
  input  logic [1:0] cfg_sel,
  input  logic [7:0] cfg_wdata,
  input  logic       ack,
  output logic       irq_out,
  output logic [2:0] ack_vec
);
  logic [NLVL-1:0] mask_q, isr_q, elig, isr_set, isr_clr;
  lvl_t            low_q, win_lvl, win_rank, isr_lvl, isr_rank;
  logic            elig_any, isr_any, eoi_hit, ack_hit;

  pic_state u_state (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
    .isr_set, .isr_clr, .mask_q, .low_q, .isr_q
  );

  // highest level currently in service
  pic_resolve u_isr_top (
    .cand(isr_q), .low(low_q), .any(isr_any),
    .win_lvl(isr_lvl), .win_rank(isr_rank)
  );

  for (genvar i = 0; i < NLVL; i++) begin : g_elig
    assign elig[i] = irq_req[i] & ~mask_q[i] &
                     (~isr_any | (rank_of(lvl_t'(i), low_q) > isr_rank));
  end

  pic_resolve u_win (
    .cand(elig), .low(low_q), .any(elig_any),
    .win_lvl(win_lvl), .win_rank(win_rank)
  );

  assign ack_hit = ack & elig_any;
  assign eoi_hit = cfg_we & (cfg_sel == SEL_EOI) & isr_any;
  assign isr_set = ack_hit ? onehot(win_lvl) : '0;
  assign isr_clr = eoi_hit ? onehot(isr_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
      ack_vec <= '0;
    end else begin
      irq_out <= elig_any;
      if (ack) ack_vec <= win_lvl;
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk
  import pic_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      irq_req,
  input logic            ack,
  input logic            irq_out,
  input logic [2:0]      ack_vec,
  input logic [NLVL-1:0] mask_q,
  input logic [NLVL-1:0] isr_q,
  input logic            elig_any,
  input logic            eoi_hit
);
  // R2
  masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(|(irq_req & ~mask_q)));
  // R3
  drop_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(irq_req & ~mask_q)) |=> !irq_out);
  // R5
  ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && elig_any) |=> isr_q[ack_vec]);
  // R5
  one_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(isr_q & ~$past(isr_q)) <= 1));
  // R7
  eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !ack) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
  // R8
  spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !elig_any && !eoi_hit) |=> $stable(isr_q));
endmodule

bind prio_irq_ctrl pic_chk u_chk (.*);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_req = 8'h00, cfg_wdata = 8'h00;
  logic cfg_we = 1'b0, ack = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic irq_out;
  logic [2:0] ack_vec;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u0 (.*);

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  function automatic int rnk(int lvl, int low);
    return (lvl + 8 - low) % 8;
  endfunction

  // winning level, or -1 when nothing is eligible
  function automatic int model_win(logic [7:0] req, logic [7:0] msk,
                                   logic [7:0] isr, int low);
    int top = -1, best = -1, bl = -1;
    for (int i = 0; i < 8; i++) if (isr[i] && rnk(i, low) > top) top = rnk(i, low);
    for (int i = 0; i < 8; i++)
      if (req[i] && !msk[i] && rnk(i, low) > top && rnk(i, low) > best) begin
        best = rnk(i, low); bl = i;
      end
    return bl;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w;
    irq_req = 8'hFF;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 irq masked at reset", irq_out, 0);
    chk("R1 vec at reset", ack_vec, 0);
    do_ack();
    chk("R8 spurious vec = L", ack_vec, 0);
    irq_req = 8'h00;
    cfg(2'd0, 8'h00);
    irq_req = 8'h01;
    @(negedge clk);
    chk("R1 nothing in service after masked ack", irq_out, 1);
    irq_req = 8'h00;
    @(negedge clk);

    // sweep: every lowest level, every pattern
    for (int low = 0; low < 8; low++) begin
      cfg(2'd1, 8'(low));
      for (int p = 0; p < 256; p++) begin
        irq_req = 8'(p);
        @(negedge clk);
        chk("R3 R4 irq raised", irq_out, p != 0);
        w = model_win(8'(p), 8'h00, 8'h00, low);
        do_ack();
        chk(p == 0 ? "R8 spurious vec" : "R4 R5 winner vec", ack_vec, w < 0 ? low : w);
        @(negedge clk);
        chk("R6 winner blocks lower", irq_out, 0);
        cfg(2'd2, 8'h00);
        irq_req = 8'h00;
        @(negedge clk);
      end
    end

    // nesting with default order
    cfg(2'd1, 8'h00);
    irq_req = 8'h08;
    @(negedge clk);
    do_ack();
    chk("R5 vec 3", ack_vec, 3);
    irq_req = 8'h0C;
    @(negedge clk); @(negedge clk);
    chk("R6 lower level 2 blocked", irq_out, 0);
    irq_req = 8'h2C;
    @(negedge clk);
    chk("R6 higher level 5 nests", irq_out, 1);
    do_ack();
    chk("R5 vec 5", ack_vec, 5);
    irq_req = 8'h10;
    @(negedge clk); @(negedge clk);
    chk("R6 level 4 blocked by 5", irq_out, 0);
    cfg(2'd2, 8'h00);
    @(negedge clk);
    chk("R7 eoi releases 5 only, 4 passes", irq_out, 1);
    irq_req = 8'h04;
    @(negedge clk); @(negedge clk);
    chk("R7 level 3 still in service", irq_out, 0);
    cfg(2'd2, 8'h00);
    @(negedge clk);
    chk("R7 second eoi releases 3", irq_out, 1);
    cfg(2'd2, 8'h00);
    @(negedge clk);
    chk("R7 eoi with empty service harmless", irq_out, 1);
    cfg(2'd3, 8'hFF);
    @(negedge clk);
    chk("R3 select 3 ignored", irq_out, 1);
    // mask while held
    cfg(2'd0, 8'h04);
    chk("R3 one edge of delay", irq_out, 1);
    @(negedge clk);
    chk("R2 masked level drops irq", irq_out, 0);
    irq_req = 8'hFF;
    cfg(2'd0, 8'hFF);
    @(negedge clk);
    chk("R2 all masked", irq_out, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule